// File: doc/BRIEF.md
# Data Translation Fault Recorder

This block is the data-side translation check for loads and stores. Each request carries a virtual address, the access kind, the request flags, the opcode and destination-register fields, and the result of a page-table cache lookup made beside it. The block picks the effective privilege mode and applies the physical, superpage and mapped-page rules. It then produces a physical address and a fault code. The page-table cache storage itself lives outside the block.

When a translation fault is found, the block records three things. The first is the faulting address. The second is a 17-bit status word packed from the opcode, the register number and six cause flags. The third is a formatted address that points into the page table. These records freeze until software reads the fault address register, which is signalled on `fa_read`. Saturating event counters count read and write hits, misses and violations.

Requests enter on a valid/ready stream and results leave on another. A result appears one cycle after its request is accepted. While `rsp_ready` is low, the result is held unchanged and `req_ready` stays low, so back-pressure reaches the requester directly.

Top module: `dxlate_fault_unit`

## Requirements
- R1: `req_ready` is high exactly when no result is waiting or `rsp_ready` is high. A request accepted on a clock edge shows up on `rsp_valid`, `rsp_paddr` and `rsp_fault` right after that edge. A result left waiting under low `rsp_ready` keeps its values.
- R2: Mode codes are kernel=0, executive=1, supervisor=2 and user=3. Permission checks use the effective mode: `cur_mode` normally, kernel when `req_pc_priv` is set, and `alt_mode` when both `req_pc_priv` and `req_alt` are set. Mode m selects bit m of `tlb_rd_en` and of `tlb_wr_en`.
- R3: Fault codes are 0 none, 1 general, 2 violation, 3 miss, 4 page-table miss and 5 machine check. With `req_phys` set, the physical address equals the virtual address and no translation check applies.
- R4: A virtual address whose bits 63..43 do not all equal bit 42 gives a general fault. Its causes are bad-VA and violation, plus write for stores.
- R5: When `spage_en[1]` is set and VA[42:41]=2, the access is a superpage access. It maps to VA bits 43..0 when `cur_mode` is kernel. Otherwise it gives a violation fault with the violation cause, plus write for stores.
- R6: A page-table cache miss gives the miss cause, plus write for stores. The fault code is 4 when `req_ptacc` is set and 3 otherwise.
- R7: On a hit, the physical address is the frame number above the 13 page-offset bits. A store without write permission is a general fault with causes write, violation and fault-on-write (the last only if the entry's bit is set). A permitted store whose fault-on-write bit is set is a general fault with causes write and fault-on-write.
- R8: A load without read permission is a violation fault with the violation cause, plus fault-on-read if the entry's bit is set. A permitted load whose fault-on-read bit is set is a general fault with the fault-on-read cause.
- R9: A translation without fault whose physical address has any bit at position 44 or above gives a machine-check fault and makes no record.
- R10: The cause flags sit at these bit positions: write at bit 0, violation at bit 1, fault-on-read at bit 2, fault-on-write at bit 3, miss at bit 4 and bad-VA at bit 5. `fa_stat` is {opcode[5:0], ra[4:0], causes[5:0]}, and `fa_form` is `ptbase` ORed with VA[42:13] shifted left by 3.
- R11: A fault with code 1 to 4 writes `fa_addr`, `fa_stat` and `fa_form` and sets `fa_locked`, but only when `req_misspec` is low and `fa_locked` is low. A high `fa_read` clears `fa_locked`.
- R12: Six counters (read hit, write hit, read miss, write miss, read violation, write violation) each add one per accepted request of their class and saturate at all ones. Any result with code 0 or 5 counts as a hit, codes 3 and 4 count as misses, and codes 1 and 2 count as violations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | Store (1) or load (0) |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode in privileged code |
| req_ptacc | input | 1 | Access is a page-table access |
| req_misspec | input | 1 | Access is misspeculated; do not record |
| req_pc_priv | input | 1 | Issuing PC lies in privileged code |
| req_opcode | input | 6 | Opcode field for the status word |
| req_ra | input | 5 | Register field for the status word |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_pfn | input | 51 | Page frame number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Entry fault-on-read bit |
| tlb_fow | input | 1 | Entry fault-on-write bit |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| spage_en | input | 2 | Superpage enable field |
| ptbase | input | 64 | Page table base for the formatted address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | 64 | Physical address |
| rsp_fault | output | 3 | Fault code |
| fa_read | input | 1 | Fault address register is read this cycle |
| fa_addr | output | 64 | Recorded faulting address |
| fa_stat | output | 17 | Recorded status word |
| fa_form | output | 64 | Recorded formatted address |
| fa_locked | output | 1 | Records are frozen |
| cnt_rd_hit | output | CNT_W | Read hit count |
| cnt_wr_hit | output | CNT_W | Write hit count |
| cnt_rd_miss | output | CNT_W | Read miss count |
| cnt_wr_miss | output | CNT_W | Write miss count |
| cnt_rd_acv | output | CNT_W | Read violation count |
| cnt_wr_acv | output | CNT_W | Write violation count |

## Verification
The test requests cover each path: physical, bad address, superpage in kernel and in user mode, miss with and without the page-table flag, and mapped hits under every combination of permission and fault-on bits. Together these show that each path yields its own fault code and cause set. Requests that differ only in the privileged-PC and alternate flags show that the effective mode comes from the right register. Faults arriving while the records are locked, or marked misspeculated, show that a record is written only when allowed. Results are drained under an irregular ready pattern, which exposes any change to a held output, and a long run of read hits on a narrow counter drives it into saturation.

// File: rtl/dxf_pkg.sv
package dxf_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_GENERAL = 3'd1,
    FLT_ACV     = 3'd2,
    FLT_MISS    = 3'd3,
    FLT_PT_MISS = 3'd4,
    FLT_MCHK    = 3'd5
  } fault_e;

  localparam int CZ_WR    = 0;
  localparam int CZ_ACV   = 1;
  localparam int CZ_FOR   = 2;
  localparam int CZ_FOW   = 3;
  localparam int CZ_MISS  = 4;
  localparam int CZ_BADVA = 5;
  localparam int CZ_W     = 6;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  localparam int EV_RD_HIT  = 0;
  localparam int EV_WR_HIT  = 1;
  localparam int EV_RD_MISS = 2;
  localparam int EV_WR_MISS = 3;
  localparam int EV_RD_ACV  = 4;
  localparam int EV_WR_ACV  = 5;
  localparam int EV_N       = 6;
endpackage

// File: rtl/dxf_mode_sel.sv
module dxf_mode_sel (
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  input  logic       pc_priv,
  input  logic       use_alt,
  output logic [1:0] eff_mode
);
  import dxf_pkg::*;

  always_comb begin
    if (!pc_priv)     eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end
endmodule

// File: rtl/dxf_classify.sv
module dxf_classify #(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 43,
  parameter int PA_W     = 44,
  parameter int PG_SHIFT = 13,
  parameter int PFN_W    = VA_W - PG_SHIFT
) (
  input  logic [VA_W-1:0]      vaddr,
  input  logic                 write,
  input  logic                 phys,
  input  logic                 ptacc,
  input  logic [1:0]           cur_mode,
  input  logic [1:0]           eff_mode,
  input  logic [1:0]           spage_en,
  input  logic                 tlb_hit,
  input  logic [PFN_W-1:0]     tlb_pfn,
  input  logic [3:0]           tlb_rd_en,
  input  logic [3:0]           tlb_wr_en,
  input  logic                 tlb_for,
  input  logic                 tlb_fow,
  output logic [VA_W-1:0]      paddr,
  output dxf_pkg::fault_e      fault,
  output logic [dxf_pkg::CZ_W-1:0] cause,
  output logic                 ev_hit,
  output logic                 ev_miss,
  output logic                 ev_acv
);
  import dxf_pkg::*;

  localparam int HI_W = VA_W - VA_IMPL + 1;
  localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [HI_W-1:0] va_hi;
  logic            va_ok;
  logic            sp_map;
  logic [3:0]      mode_sel;
  logic            rd_ok;
  logic            wr_ok;
  logic            xl_ok;
  logic [VA_W-1:0] pa_raw;

  assign va_hi    = vaddr[VA_W-1:VA_IMPL-1];
  assign va_ok    = (&va_hi) | ~(|va_hi);
  assign sp_map   = spage_en[1] && (vaddr[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign mode_sel = 4'b0001 << eff_mode;
  assign rd_ok    = |(tlb_rd_en & mode_sel);
  assign wr_ok    = |(tlb_wr_en & mode_sel);

  always_comb begin
    pa_raw = vaddr;
    fault  = FLT_NONE;
    cause  = '0;
    xl_ok  = 1'b0;
    if (phys) begin
      xl_ok = 1'b1;
    end else if (!va_ok) begin
      cause[CZ_WR]    = write;
      cause[CZ_ACV]   = 1'b1;
      cause[CZ_BADVA] = 1'b1;
      fault           = FLT_GENERAL;
    end else if (sp_map) begin
      pa_raw = vaddr & PA_MASK;
      if (cur_mode != MODE_KERNEL) begin
        cause[CZ_WR]  = write;
        cause[CZ_ACV] = 1'b1;
        fault         = FLT_ACV;
      end else begin
        xl_ok = 1'b1;
      end
    end else if (!tlb_hit) begin
      cause[CZ_WR]   = write;
      cause[CZ_MISS] = 1'b1;
      fault          = ptacc ? FLT_PT_MISS : FLT_MISS;
    end else begin
      pa_raw = {tlb_pfn, vaddr[PG_SHIFT-1:0]};
      if (write) begin
        cause[CZ_WR] = 1'b1;
        if (!wr_ok) begin
          cause[CZ_ACV] = 1'b1;
          cause[CZ_FOW] = tlb_fow;
          fault         = FLT_GENERAL;
        end else if (tlb_fow) begin
          cause[CZ_FOW] = 1'b1;
          fault         = FLT_GENERAL;
        end else begin
          cause[CZ_WR] = 1'b0;
          xl_ok        = 1'b1;
        end
      end else begin
        if (!rd_ok) begin
          cause[CZ_ACV] = 1'b1;
          cause[CZ_FOR] = tlb_for;
          fault         = FLT_ACV;
        end else if (tlb_for) begin
          cause[CZ_FOR] = 1'b1;
          fault         = FLT_GENERAL;
        end else begin
          xl_ok = 1'b1;
        end
      end
    end
    if (xl_ok && (|pa_raw[VA_W-1:PA_W])) fault = FLT_MCHK;
  end

  assign paddr   = pa_raw;
  assign ev_hit  = xl_ok;
  assign ev_miss = (fault == FLT_MISS) || (fault == FLT_PT_MISS);
  assign ev_acv  = (fault == FLT_GENERAL) || (fault == FLT_ACV);
endmodule

// File: rtl/dxf_fault_rec.sv
module dxf_fault_rec #(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 43,
  parameter int PG_SHIFT = 13,
  parameter int STAT_W   = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [VA_W-1:0]          vaddr,
  input  logic [5:0]               opcode,
  input  logic [4:0]               ra,
  input  logic [dxf_pkg::CZ_W-1:0] cause,
  input  logic [VA_W-1:0]          ptbase,
  input  logic                     fa_read,
  output logic [VA_W-1:0]          fa_addr,
  output logic [STAT_W-1:0]        fa_stat,
  output logic [VA_W-1:0]          fa_form,
  output logic                     fa_locked
);
  localparam int VPN_W = VA_IMPL - PG_SHIFT;

  logic [VA_W-1:0] vpn_ext;
  logic            take;

  assign vpn_ext = {{(VA_W-VPN_W){1'b0}}, vaddr[VA_IMPL-1:PG_SHIFT]};
  assign take    = capture && !fa_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_addr   <= '0;
      fa_stat   <= '0;
      fa_form   <= '0;
      fa_locked <= 1'b0;
    end else if (take) begin
      fa_addr   <= vaddr;
      fa_stat   <= {opcode, ra, cause};
      fa_form   <= ptbase | (vpn_ext << 3);
      fa_locked <= 1'b1;
    end else if (fa_read) begin
      fa_locked <= 1'b0;
    end
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_locked && !fa_read) |=> (fa_locked && $stable(fa_addr) && $stable(fa_stat) && $stable(fa_form)))
    else $error("locked record changed"); // R11
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_locked && fa_read) |=> !fa_locked)
    else $error("lock not released"); // R11
  AST_STAT_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !fa_locked) |=> (fa_stat[STAT_W-1:STAT_W-6] == $past(opcode)))
    else $error("status opcode field wrong"); // R10
endmodule

// File: rtl/dxf_counters.sv
module dxf_counters #(
  parameter int CNT_W = 32,
  parameter int N     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              inc,
  output logic [N-1:0][CNT_W-1:0]   cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                          cnt[g] <= '0;
      else if (inc[g] && (cnt[g] != MAXV)) cnt[g] <= cnt[g] + 1'b1;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == MAXV) |=> (cnt[g] == MAXV))
      else $error("counter left saturation"); // R12
  end
endmodule

// File: rtl/dxlate_fault_unit.sv
module dxlate_fault_unit #(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 43,
  parameter int PA_W     = 44,
  parameter int PG_SHIFT = 13,
  parameter int PFN_W    = 51,
  parameter int CNT_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_phys,
  input  logic               req_alt,
  input  logic               req_ptacc,
  input  logic               req_misspec,
  input  logic               req_pc_priv,
  input  logic [5:0]         req_opcode,
  input  logic [4:0]         req_ra,
  input  logic               tlb_hit,
  input  logic [PFN_W-1:0]   tlb_pfn,
  input  logic [3:0]         tlb_rd_en,
  input  logic [3:0]         tlb_wr_en,
  input  logic               tlb_for,
  input  logic               tlb_fow,
  input  logic [1:0]         cur_mode,
  input  logic [1:0]         alt_mode,
  input  logic [1:0]         spage_en,
  input  logic [VA_W-1:0]    ptbase,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [2:0]         rsp_fault,
  input  logic               fa_read,
  output logic [VA_W-1:0]    fa_addr,
  output logic [16:0]        fa_stat,
  output logic [VA_W-1:0]    fa_form,
  output logic               fa_locked,
  output logic [CNT_W-1:0]   cnt_rd_hit,
  output logic [CNT_W-1:0]   cnt_wr_hit,
  output logic [CNT_W-1:0]   cnt_rd_miss,
  output logic [CNT_W-1:0]   cnt_wr_miss,
  output logic [CNT_W-1:0]   cnt_rd_acv,
  output logic [CNT_W-1:0]   cnt_wr_acv
);
  import dxf_pkg::*;

  logic [1:0]              eff_mode;
  logic [VA_W-1:0]         cls_paddr;
  fault_e                  cls_fault;
  logic [CZ_W-1:0]         cls_cause;
  logic                    ev_hit, ev_miss, ev_acv;
  logic                    accept;
  logic                    rec_fault;
  logic [EV_N-1:0]         ev_inc;
  logic [EV_N-1:0][CNT_W-1:0] cnt_all;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  dxf_mode_sel u_mode (
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .pc_priv  (req_pc_priv),
    .use_alt  (req_alt),
    .eff_mode (eff_mode)
  );

  dxf_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .PFN_W(PFN_W)
  ) u_cls (
    .vaddr     (req_vaddr),
    .write     (req_write),
    .phys      (req_phys),
    .ptacc     (req_ptacc),
    .cur_mode  (cur_mode),
    .eff_mode  (eff_mode),
    .spage_en  (spage_en),
    .tlb_hit   (tlb_hit),
    .tlb_pfn   (tlb_pfn),
    .tlb_rd_en (tlb_rd_en),
    .tlb_wr_en (tlb_wr_en),
    .tlb_for   (tlb_for),
    .tlb_fow   (tlb_fow),
    .paddr     (cls_paddr),
    .fault     (cls_fault),
    .cause     (cls_cause),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_acv    (ev_acv)
  );

  assign rec_fault = (cls_fault != FLT_NONE) && (cls_fault != FLT_MCHK);

  dxf_fault_rec #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PG_SHIFT(PG_SHIFT), .STAT_W(17)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept && rec_fault && !req_misspec),
    .vaddr     (req_vaddr),
    .opcode    (req_opcode),
    .ra        (req_ra),
    .cause     (cls_cause),
    .ptbase    (ptbase),
    .fa_read   (fa_read),
    .fa_addr   (fa_addr),
    .fa_stat   (fa_stat),
    .fa_form   (fa_form),
    .fa_locked (fa_locked)
  );

  always_comb begin
    ev_inc             = '0;
    ev_inc[EV_RD_HIT]  = accept && ev_hit  && !req_write;
    ev_inc[EV_WR_HIT]  = accept && ev_hit  &&  req_write;
    ev_inc[EV_RD_MISS] = accept && ev_miss && !req_write;
    ev_inc[EV_WR_MISS] = accept && ev_miss &&  req_write;
    ev_inc[EV_RD_ACV]  = accept && ev_acv  && !req_write;
    ev_inc[EV_WR_ACV]  = accept && ev_acv  &&  req_write;
  end

  dxf_counters #(.CNT_W(CNT_W), .N(EV_N)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_inc),
    .cnt   (cnt_all)
  );

  assign cnt_rd_hit  = cnt_all[EV_RD_HIT];
  assign cnt_wr_hit  = cnt_all[EV_WR_HIT];
  assign cnt_rd_miss = cnt_all[EV_RD_MISS];
  assign cnt_wr_miss = cnt_all[EV_WR_MISS];
  assign cnt_rd_acv  = cnt_all[EV_RD_ACV];
  assign cnt_wr_acv  = cnt_all[EV_WR_ACV];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= cls_paddr;
      rsp_fault <= cls_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)))
    else $error("held result changed"); // R1
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid)
    else $error("accepted request produced no result"); // R1
  AST_PT_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cls_fault == FLT_PT_MISS)) |-> (req_ptacc && !tlb_hit))
    else $error("page-table miss without page-table access"); // R6
  AST_MCHK_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cls_fault == FLT_MCHK) && !fa_locked && !fa_read) |=> !fa_locked)
    else $error("machine check recorded"); // R9
endmodule

// File: tb/dxlate_fault_unit_tb_top.sv
module dxlate_fault_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] d_vaddr = '0;
  logic d_write = 0, d_phys = 0, d_alt = 0, d_pt = 0, d_mis = 0, d_priv = 0;
  logic [5:0] d_op = 6'h2a;
  logic [4:0] d_ra = 5'h13;
  logic t_hit = 0;
  logic [50:0] t_pfn = '0;
  logic [3:0] t_rd = 4'hf, t_wr = 4'hf;
  logic t_for = 0, t_fow = 0;
  logic [1:0] cur_mode = 0, alt_mode = 0, spage_en = 0;
  logic [63:0] ptbase = 64'h0000_0002_0000_0000;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [63:0] rsp_paddr;
  logic [2:0] rsp_fault;
  logic fa_read = 0;
  logic [63:0] fa_addr, fa_form;
  logic [16:0] fa_stat;
  logic fa_locked;
  logic [CW-1:0] c_rh, c_wh, c_rm, c_wm, c_ra, c_wa;

  dxlate_fault_unit #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(d_vaddr), .req_write(d_write), .req_phys(d_phys), .req_alt(d_alt),
    .req_ptacc(d_pt), .req_misspec(d_mis), .req_pc_priv(d_priv), .req_opcode(d_op),
    .req_ra(d_ra), .tlb_hit(t_hit), .tlb_pfn(t_pfn), .tlb_rd_en(t_rd), .tlb_wr_en(t_wr),
    .tlb_for(t_for), .tlb_fow(t_fow), .cur_mode(cur_mode), .alt_mode(alt_mode),
    .spage_en(spage_en), .ptbase(ptbase), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .fa_read(fa_read), .fa_addr(fa_addr),
    .fa_stat(fa_stat), .fa_form(fa_form), .fa_locked(fa_locked),
    .cnt_rd_hit(c_rh), .cnt_wr_hit(c_wh), .cnt_rd_miss(c_rm), .cnt_wr_miss(c_wm),
    .cnt_rd_acv(c_ra), .cnt_wr_acv(c_wa)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [63:0] pa;
    logic [2:0]  flt;
    string       req;
  } item_t;
  item_t exp_q[$];

  logic m_lock = 0;
  logic [63:0] m_addr = '0, m_form = '0;
  logic [16:0] m_stat = '0;
  int m_cnt[6] = '{0, 0, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outcome derived from the requirements.
  function automatic void model(output logic [63:0] pa, output logic [2:0] flt, output logic [5:0] cz);
    logic [1:0] em;
    logic [21:0] hi;
    bit ok;
    em = d_priv ? (d_alt ? alt_mode : 2'd0) : cur_mode;
    hi = d_vaddr[63:42];
    pa = d_vaddr; flt = 3'd0; cz = '0; ok = 0;
    if (d_phys) ok = 1;
    else if (!(hi == '0 || hi == '1)) begin cz = {1'b1, 3'b0, 1'b1, d_write}; flt = 3'd1; end
    else if (spage_en[1] && d_vaddr[42:41] == 2'b10) begin
      pa = d_vaddr & 64'h0000_0FFF_FFFF_FFFF;
      if (cur_mode != 2'd0) begin cz = {4'b0, 1'b1, d_write}; flt = 3'd2; end
      else ok = 1;
    end else if (!t_hit) begin cz = {1'b0, 1'b1, 3'b0, d_write}; flt = d_pt ? 3'd4 : 3'd3; end
    else begin
      pa = {t_pfn, d_vaddr[12:0]};
      if (d_write) begin
        if (!t_wr[em]) begin cz = {2'b0, t_fow, 1'b0, 2'b11}; flt = 3'd1; end
        else if (t_fow) begin cz = 6'b001001; flt = 3'd1; end
        else ok = 1;
      end else begin
        if (!t_rd[em]) begin cz = {3'b0, t_for, 2'b10}; flt = 3'd2; end
        else if (t_for) begin cz = 6'b000100; flt = 3'd1; end
        else ok = 1;
      end
    end
    if (ok && pa[63:44] != '0) flt = 3'd5;
  endfunction

  task automatic send(input string req);
    logic [63:0] pa; logic [2:0] flt; logic [5:0] cz; item_t it; int cls;
    model(pa, flt, cz);
    it.pa = pa; it.flt = flt; it.req = req;
    exp_q.push_back(it);
    cls = (flt == 0 || flt == 5) ? 0 : ((flt == 3 || flt == 4) ? 2 : 4);
    cls = cls + (d_write ? 1 : 0);
    if (m_cnt[cls] < (1 << CW) - 1) m_cnt[cls]++;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flt >= 1 && flt <= 4 && !d_mis && !m_lock) begin
      m_lock = 1; m_addr = d_vaddr; m_stat = {d_op, d_ra, cz};
      m_form = ptbase | ({34'b0, d_vaddr[42:13]} << 3);
    end
    chk(fa_locked == m_lock, {req, " R11 lock"}, 64'(fa_locked), 64'(m_lock));
    chk(fa_addr == m_addr, {req, " R11 fa_addr"}, fa_addr, m_addr);
    chk(fa_stat == m_stat, {req, " R10 fa_stat"}, 64'(fa_stat), 64'(m_stat));
    chk(fa_form == m_form, {req, " R10 fa_form"}, fa_form, m_form);
  endtask

  task automatic read_fa();
    fa_read = 1'b1;
    @(negedge clk);
    fa_read = 1'b0;
    m_lock = 0;
    chk(fa_locked == 1'b0, "R11 unlock on read", 64'(fa_locked), 64'd0);
  endtask

  // Irregular consumer back-pressure, updated away from the sampling edge.
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 rsp_ready <= ((cyc % 7) != 3) && ((cyc % 5) != 1);
  end

  // Monitor: compare transferred results, check held results are stable.
  logic hold_prev = 0;
  logic [63:0] pa_prev;
  logic [2:0] flt_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        chk(rsp_valid && rsp_paddr == pa_prev && rsp_fault == flt_prev,
            "R1 held result stable", rsp_paddr, pa_prev);
      end
      chk(req_ready == (!rsp_valid || rsp_ready), "R1 ready rule", 64'(req_ready),
          64'(!rsp_valid || rsp_ready));
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected result", 64'(rsp_fault), 64'd0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(rsp_fault == it.flt, {it.req, " fault"}, 64'(rsp_fault), 64'(it.flt));
          chk(rsp_paddr == it.pa, {it.req, " paddr"}, rsp_paddr, it.pa);
        end
      end
      hold_prev = rsp_valid && !rsp_ready;
      pa_prev = rsp_paddr; flt_prev = rsp_fault;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0 && fa_locked == 0 && c_rh == 0 && c_wa == 0, "R1 reset state",
        64'({rsp_valid, fa_locked}), 64'd0);

    // R3 physical
    d_phys = 1; d_vaddr = 64'h0000_0ABC_DEF0_1234; send("R3 physical pass");
    d_vaddr = 64'h0010_0000_0000_0040; send("R9 physical machine check");
    d_phys = 0;
    // R4 bad VA, then locked store bad VA
    d_vaddr = 64'h0001_0000_0000_2000; send("R4 bad VA load");
    d_write = 1; d_op = 6'h0d; d_vaddr = 64'h0002_0000_0000_4000; send("R4 bad VA store while locked");
    read_fa();
    send("R4 bad VA store");
    read_fa();
    // R5 superpage
    spage_en = 2'b10; d_write = 0;
    d_vaddr = 64'hFFFF_FC00_1234_5678; send("R5 superpage kernel");
    cur_mode = 2'd3; d_write = 1; send("R5 superpage user store");
    read_fa();
    spage_en = 2'b01; cur_mode = 0; t_hit = 1; t_pfn = 51'h12345; d_write = 0;
    send("R5 superpage disabled maps via entry");
    // R6 misses
    t_hit = 0; d_pt = 1; d_vaddr = 64'h0000_0000_0040_6000; send("R6 page-table miss");
    read_fa();
    d_pt = 0; d_write = 1; send("R6 normal store miss");
    read_fa();
    // R11 misspeculated fault not recorded
    d_mis = 1; d_write = 0; send("R11 misspeculated miss");
    d_mis = 0;
    // R2 mode selection and R8 loads
    t_hit = 1; t_pfn = 51'h00777; cur_mode = 2'd3; t_rd = 4'b0001; t_for = 1;
    d_vaddr = 64'h0000_0001_0000_2abc;
    send("R8 user load no read enable");
    read_fa();
    t_for = 0; d_priv = 1; send("R2 privileged pc uses kernel");
    d_alt = 1; alt_mode = 2'd2; send("R2 alternate mode supervisor denied");
    read_fa();
    t_rd = 4'b0100; send("R2 alternate mode supervisor allowed");
    d_priv = 0; d_alt = 0; cur_mode = 0; t_rd = 4'hf; t_for = 1; send("R8 permitted load fault-on-read");
    read_fa();
    t_for = 0;
    // R7 stores
    d_write = 1; t_fow = 1; send("R7 permitted store fault-on-write");
    read_fa();
    t_wr = 4'b1110; send("R7 store no write enable");
    read_fa();
    t_fow = 0; t_wr = 4'hf; send("R7 permitted store");
    // R9 mapped machine check
    d_write = 0; t_pfn = 51'h1_0000_0000; send("R9 mapped machine check");
    // R12 saturate read hits
    t_pfn = 51'h55;
    for (int i = 0; i < 18; i++) begin
      d_vaddr = 64'h0000_0000_0002_0000 + 64'(i * 8);
      send("R12 read hit burst");
    end
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all results drained", 64'(exp_q.size()), 64'd0);
    chk(c_rh == CW'(m_cnt[0]), "R12 read hit count", 64'(c_rh), 64'(m_cnt[0]));
    chk(c_wh == CW'(m_cnt[1]), "R12 write hit count", 64'(c_wh), 64'(m_cnt[1]));
    chk(c_rm == CW'(m_cnt[2]), "R12 read miss count", 64'(c_rm), 64'(m_cnt[2]));
    chk(c_wm == CW'(m_cnt[3]), "R12 write miss count", 64'(c_wm), 64'(m_cnt[3]));
    chk(c_ra == CW'(m_cnt[4]), "R12 read violation count", 64'(c_ra), 64'(m_cnt[4]));
    chk(c_wa == CW'(m_cnt[5]), "R12 write violation count", 64'(c_wa), 64'(m_cnt[5]));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule